// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block sits on a single serial memory request stream and judges exclusive accesses from many requesters. Each request carries a requester ID, a word address, a read/write flag, an exclusive flag and write data. An exclusive read always returns the stored word and leaves behind a reservation that ties the ID to that address. A later exclusive write from the same ID is carried out only while that reservation is still held. Otherwise the write is dropped and the requester is told it lost, so its software loop can retry.

Reservations live in a small table with one entry per ID. Different IDs can hold reservations on the same address at the same time. The first of them to store wins, and its store removes every other reservation on that address. A plain store does the same. When the table is full, a new reservation pushes out an older one in rotating order. The evicted requester's next exclusive write then fails even though nothing conflicted with it. A small word memory behind the monitor holds the data, and every request gets a response exactly one cycle later.

Top module: `excl_mon_top`

## Requirements
- R1: An exclusive read returns the addressed memory word with response code EXOKAY (2'b01) and records a reservation for its ID at that address.
- R2: An exclusive write whose ID holds a reservation on exactly that address updates memory and responds EXOKAY. A reservation by the same ID on a different address does not count.
- R3: A failed exclusive write responds OKAY (2'b00) and leaves the memory word unchanged.
- R4: A normal write, or a successful exclusive write, removes every reservation on that address from all IDs. When IDs x and y both reserve an address, whichever writes first succeeds and the other's exclusive write fails.
- R5: Every exclusive write, whether it passes or fails, removes the writer's own reservation, so a second exclusive write without a new exclusive read fails.
- R6: An exclusive read from an ID that already holds a reservation replaces that reservation's address. The ID never owns two entries.
- R7: The table holds N_ENT (default 4) entries. A new ID takes the lowest free entry. When no entry is free, the ID evicts the entry at a rotating pointer that starts at 0 and advances by one per eviction. The evicted ID's next exclusive write fails.
- R8: A normal read returns the memory word with OKAY and does not change any reservation.
- R9: Each request gets exactly one response one cycle later, echoing the request ID. Write responses carry zero data, and no response appears in a cycle after no request.
- R10: Reset clears all reservations, the eviction pointer and the memory to zero, and holds rsp_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_id | input | ID_W | Requester ID |
| req_addr | input | ADDR_W | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_excl | input | 1 | 1 = exclusive access |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | ID_W | ID of the answered request |
| rsp_resp | output | 2 | 2'b00 OKAY, 2'b01 EXOKAY |
| rsp_rdata | output | DATA_W | Read data, zero for writes |

## Verification
Several rules are checked on every cycle. A failed exclusive write never raises the memory write strobe and is answered OKAY. A passing one is answered EXOKAY. Eviction happens only when the table is full, no ID ever occupies two entries, and a normal read leaves the valid bits alone. The other behaviours can only be shown by the bench's scenarios, because they depend on the order of earlier requests: interleaved reservations from two IDs in both write orders, clearing by plain stores, loss of a reservation after a failed write or a re-reservation, and the rotating choice of eviction victim.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01
  } resp_e;
endpackage

// File: rtl/excl_mon_mem.sv
module excl_mon_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  assign rdata = words[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (we) begin
      words[addr] <= wdata;
    end
  end
endmodule

// File: rtl/excl_mon_resv.sv
module excl_mon_resv #(
  parameter int N_ENT  = 4,
  parameter int ID_W   = 4,
  parameter int ADDR_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          op_xrd,
  input  logic                          op_nwr,
  input  logic                          op_xwr,
  input  logic [ID_W-1:0]               id,
  input  logic [ADDR_W-1:0]             addr,
  output logic                          xwr_pass,
  output logic                          evict_ev,
  output logic [N_ENT-1:0]              ent_valid,
  output logic [N_ENT-1:0][ID_W-1:0]    ent_id,
  output logic [N_ENT-1:0][ADDR_W-1:0]  ent_addr
);
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

  // lowest set bit of a vector, as an index
  function automatic logic [IDX_W-1:0] lowest_idx(input logic [N_ENT-1:0] v);
    lowest_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (v[i]) lowest_idx = IDX_W'(i);
  endfunction

  logic [N_ENT-1:0] id_match, addr_match;
  logic [IDX_W-1:0] rr_ptr, alloc_idx;
  logic             table_full, own_found;

  for (genvar g = 0; g < N_ENT; g++) begin : g_match
    assign id_match[g]   = ent_valid[g] && (ent_id[g] == id);
    assign addr_match[g] = ent_valid[g] && (ent_addr[g] == addr);
  end

  assign own_found  = |id_match;
  assign table_full = &ent_valid;
  assign xwr_pass   = op_xwr && |(id_match & addr_match);
  assign evict_ev   = op_xrd && !own_found && table_full;

  always_comb begin
    if (own_found)       alloc_idx = lowest_idx(id_match);
    else if (!table_full) alloc_idx = lowest_idx(~ent_valid);
    else                 alloc_idx = rr_ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      ent_id    <= '0;
      ent_addr  <= '0;
      rr_ptr    <= '0;
    end else begin
      if (op_xrd) begin
        ent_valid[alloc_idx] <= 1'b1;
        ent_id[alloc_idx]    <= id;
        ent_addr[alloc_idx]  <= addr;
        if (evict_ev) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
      end
      if (op_nwr || xwr_pass) begin
        for (int i = 0; i < N_ENT; i++)
          if (addr_match[i]) ent_valid[i] <= 1'b0;
      end else if (op_xwr) begin
        for (int i = 0; i < N_ENT; i++)
          if (id_match[i]) ent_valid[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/excl_mon_top.sv
module excl_mon_top
  import excl_mon_pkg::*;
#(
  parameter int N_ENT  = 4,
  parameter int ID_W   = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_excl,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [ID_W-1:0]   rsp_id,
  output logic [1:0]        rsp_resp,
  output logic [DATA_W-1:0] rsp_rdata
);
  // named internal events, visible to the bound checker
  logic op_xrd, op_nwr, op_xwr, xwr_pass, evict_ev, mem_we;
  logic [N_ENT-1:0]             ent_valid;
  logic [N_ENT-1:0][ID_W-1:0]   ent_id;
  logic [N_ENT-1:0][ADDR_W-1:0] ent_addr;
  logic [DATA_W-1:0]            mem_rdata;
  resp_e                        resp_nxt;

  assign op_xrd = req_valid && !req_write && req_excl;
  assign op_nwr = req_valid && req_write && !req_excl;
  assign op_xwr = req_valid && req_write && req_excl;
  assign mem_we = op_nwr || xwr_pass;

  excl_mon_resv #(.N_ENT(N_ENT), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_resv (
    .clk(clk), .rst_n(rst_n),
    .op_xrd(op_xrd), .op_nwr(op_nwr), .op_xwr(op_xwr),
    .id(req_id), .addr(req_addr),
    .xwr_pass(xwr_pass), .evict_ev(evict_ev),
    .ent_valid(ent_valid), .ent_id(ent_id), .ent_addr(ent_addr)
  );

  excl_mon_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we),
    .addr(req_addr), .wdata(req_wdata), .rdata(mem_rdata)
  );

  assign resp_nxt = (op_xrd || xwr_pass) ? RESP_EXOKAY : RESP_OKAY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_resp  <= RESP_OKAY;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_id    <= req_id;
      rsp_resp  <= resp_nxt;
      rsp_rdata <= req_write ? '0 : mem_rdata;
    end
  end
endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk #(
  parameter int N_ENT = 4,
  parameter int ID_W  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_write,
  input logic                       req_excl,
  input logic                       op_xwr,
  input logic                       xwr_pass,
  input logic                       mem_we,
  input logic                       evict_ev,
  input logic [N_ENT-1:0]           ent_valid,
  input logic [N_ENT-1:0][ID_W-1:0] ent_id,
  input logic                       rsp_valid,
  input logic [1:0]                 rsp_resp
);
  logic dup_id;
  always_comb begin
    dup_id = 1'b0;
    for (int i = 0; i < N_ENT; i++)
      for (int j = i + 1; j < N_ENT; j++)
        if (ent_valid[i] && ent_valid[j] && ent_id[i] == ent_id[j]) dup_id = 1'b1;
  end

  p_fail_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_xwr && !xwr_pass) |-> !mem_we);

  p_fail_okay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_xwr && !xwr_pass) |=> (rsp_valid && rsp_resp == 2'b00));

  p_pass_exokay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xwr_pass |=> (rsp_valid && rsp_resp == 2'b01));

  p_evict_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evict_ev |-> (&ent_valid));

  p_single_entry_per_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_id);

  p_plain_read_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_excl) |=> $stable(ent_valid));

  p_idle_no_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
endmodule

bind excl_mon_top excl_mon_chk #(.N_ENT(N_ENT), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_excl(req_excl), .op_xwr(op_xwr), .xwr_pass(xwr_pass), .mem_we(mem_we),
  .evict_ev(evict_ev), .ent_valid(ent_valid), .ent_id(ent_id),
  .rsp_valid(rsp_valid), .rsp_resp(rsp_resp)
);

// File: tb/excl_mon_top_tb.sv
`timescale 1ns/1ps
module excl_mon_top_tb;
  localparam int ID_W = 4, ADDR_W = 6, DATA_W = 32;
  localparam int NV = 28;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ID_W-1:0]   req_id = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_write = 1'b0;
  logic              req_excl = 1'b0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic [ID_W-1:0]   rsp_id;
  logic [1:0]        rsp_resp;
  logic [DATA_W-1:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  excl_mon_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_addr(req_addr), .req_write(req_write), .req_excl(req_excl),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .rsp_resp(rsp_resp), .rsp_rdata(rsp_rdata)
  );

  // {excl, write, id, addr, wdata, exp_resp, exp_rdata}; resp 0=OKAY 1=EXOKAY
  localparam logic [77:0] VEC [NV] = '{
    {1'b0,1'b1,4'd1,6'd5, 32'h11,2'd0,32'h0 },  // R9 write data zero
    {1'b0,1'b0,4'd2,6'd5, 32'h0, 2'd0,32'h11},  // R8 plain read
    {1'b1,1'b0,4'd1,6'd5, 32'h0, 2'd1,32'h11},  // R1 x reserves
    {1'b1,1'b0,4'd2,6'd5, 32'h0, 2'd1,32'h11},  // R1 y reserves
    {1'b1,1'b1,4'd1,6'd5, 32'h22,2'd1,32'h0 },  // R2 x wins
    {1'b1,1'b1,4'd2,6'd5, 32'h33,2'd0,32'h0 },  // R4 y loses
    {1'b0,1'b0,4'd3,6'd5, 32'h0, 2'd0,32'h22},  // R3 memory kept
    {1'b1,1'b0,4'd1,6'd6, 32'h0, 2'd1,32'h0 },  // R1
    {1'b1,1'b0,4'd2,6'd6, 32'h0, 2'd1,32'h0 },  // R1
    {1'b1,1'b1,4'd2,6'd6, 32'h44,2'd1,32'h0 },  // R2 y wins
    {1'b1,1'b1,4'd1,6'd6, 32'h55,2'd0,32'h0 },  // R4 x loses
    {1'b0,1'b0,4'd1,6'd6, 32'h0, 2'd0,32'h44},  // R3
    {1'b1,1'b0,4'd3,6'd7, 32'h0, 2'd1,32'h0 },  // R1
    {1'b0,1'b0,4'd4,6'd7, 32'h0, 2'd0,32'h0 },  // R8
    {1'b1,1'b1,4'd3,6'd7, 32'h66,2'd1,32'h0 },  // R8 survived read
    {1'b1,1'b1,4'd3,6'd7, 32'h77,2'd0,32'h0 },  // R5 own cleared
    {1'b1,1'b0,4'd4,6'd8, 32'h0, 2'd1,32'h0 },  // R1
    {1'b0,1'b1,4'd5,6'd8, 32'h99,2'd0,32'h0 },  // R4 plain store
    {1'b1,1'b1,4'd4,6'd8, 32'hAA,2'd0,32'h0 },  // R4 killed
    {1'b0,1'b0,4'd5,6'd8, 32'h0, 2'd0,32'h99},  // R3
    {1'b1,1'b0,4'd6,6'd9, 32'h0, 2'd1,32'h0 },  // R1
    {1'b1,1'b1,4'd6,6'd10,32'h1, 2'd0,32'h0 },  // R2 wrong address
    {1'b1,1'b1,4'd6,6'd9, 32'h2, 2'd0,32'h0 },  // R5 fail cleared own
    {1'b1,1'b0,4'd7,6'd11,32'h0, 2'd1,32'h0 },  // R6
    {1'b1,1'b0,4'd7,6'd12,32'h0, 2'd1,32'h0 },  // R6 replaces
    {1'b1,1'b1,4'd7,6'd11,32'h3, 2'd0,32'h0 },  // R6 old address gone
    {1'b1,1'b0,4'd7,6'd12,32'h0, 2'd1,32'h0 },  // R6
    {1'b1,1'b1,4'd7,6'd12,32'h5, 2'd1,32'h0 }   // R6
  };
  localparam int REQ [NV] = '{9,8,1,1,2,4,3,1,1,2,4,3,1,8,8,5,1,4,4,3,1,2,5,6,6,6,6,6};

  task automatic do_req(input logic ex, input logic wr, input logic [3:0] id,
                        input logic [5:0] ad, input logic [31:0] wd,
                        input logic [1:0] er, input logic [31:0] ed, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_excl = ex; req_write = wr;
    req_id = id; req_addr = ad; req_wdata = wd;
    @(posedge clk);
    #1;
    checks++;
    if (!rsp_valid || rsp_id !== id || rsp_resp !== er || rsp_rdata !== ed) begin
      errors++;
      $display("FAIL %s: got valid=%0b id=%0d resp=%0d data=%h, expected valid=1 id=%0d resp=%0d data=%h",
               tag, rsp_valid, rsp_id, rsp_resp, rsp_rdata, id, er, ed);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    req_valid = 1'b0; req_excl = 1'b0; req_write = 1'b0;
  endtask

  task automatic expect_no_rsp(input string tag);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s: got rsp_valid=%0b, expected 0", tag, rsp_valid);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 expect_no_rsp("R10 reset");
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      do_req(VEC[i][77], VEC[i][76], VEC[i][75:72], VEC[i][71:66], VEC[i][65:34],
             VEC[i][33:32], VEC[i][31:0], $sformatf("R%0d vec%0d", REQ[i], i));

    go_idle();
    @(posedge clk); #1 expect_no_rsp("R9 idle");

    // reset clears reservation and memory
    do_req(1'b1,1'b0,4'd1,6'd3,32'h0,2'd1,32'h0,"R1 pre-reset");
    go_idle();
    rst_n = 1'b0;
    @(posedge clk); #1 expect_no_rsp("R10 in reset");
    @(negedge clk) rst_n = 1'b1;
    do_req(1'b1,1'b1,4'd1,6'd3,32'h7,2'd0,32'h0,"R10 reservation gone");
    do_req(1'b0,1'b0,4'd1,6'd5,32'h0,2'd0,32'h0,"R10 memory cleared");

    // capacity and rotating eviction
    for (int k = 0; k < 4; k++)
      do_req(1'b1,1'b0,4'(k+1),6'(20+k),32'h0,2'd1,32'h0,"R7 fill");
    do_req(1'b1,1'b0,4'd5,6'd24,32'h0,2'd1,32'h0,"R7 evict slot0");
    do_req(1'b1,1'b1,4'd1,6'd20,32'h1,2'd0,32'h0,"R7 evicted fails");
    do_req(1'b1,1'b1,4'd2,6'd21,32'h2,2'd1,32'h0,"R7 survivor passes");
    do_req(1'b1,1'b0,4'd6,6'd25,32'h0,2'd1,32'h0,"R7 free slot");
    do_req(1'b1,1'b0,4'd7,6'd26,32'h0,2'd1,32'h0,"R7 evict slot1");
    do_req(1'b1,1'b1,4'd6,6'd25,32'h3,2'd0,32'h0,"R7 rotated victim fails");
    do_req(1'b1,1'b1,4'd3,6'd22,32'h4,2'd1,32'h0,"R7 kept");
    do_req(1'b1,1'b1,4'd5,6'd24,32'h5,2'd1,32'h0,"R7 kept");
    do_req(1'b1,1'b1,4'd7,6'd26,32'h6,2'd1,32'h0,"R7 kept");
    do_req(1'b0,1'b0,4'd7,6'd25,32'h0,2'd0,32'h0,"R3 failed write left zero");
    go_idle();

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule